// File: doc/BRIEF.md
# Selectable Sync/Async Control Stager

This block sits between the raw control pins of a registered datapath router and the router's datapath. It handles two separate groups of controls. The path-control group holds the route selects, the word-width bit and the register load enables. The output-enable group holds six active-low port enables.

Each group has its own mode input. When a group's mode input is low, its raw controls pass straight through to the outputs with no clock involved. When the mode input is high, the outputs come from staging registers that capture on the rising edge of a dedicated control clock.

The staging registers capture the raw controls on every control-clock edge, whatever the mode. A single pre-clock before a mode change therefore always leaves consistent data behind the multiplexer. Each group has a valid flag that stays low from reset until the first control-clock edge. While the output-enable group is in staged mode and its flag is still low, every enable is forced to the disabled level.

Top module: `ctl_stager`

## Requirements
- R1: While `pc_sync_mode` is 0, every path-control output equals its raw input in the same cycle, with no clock edge needed.
- R2: While `pc_sync_mode` is 1, the path-control outputs show the raw values captured at the most recent rising edge of `clk`. A raw change between edges has no effect until the next edge.
- R3: While `oe_sync_mode` is 0, `oe_n` equals `oe_n_in` at once, with no clock edge needed. Bit i of each vector belongs to port i, and a 0 bit means enabled.
- R4: While `oe_sync_mode` is 1 and `oe_valid` is 1, `oe_n` shows `oe_n_in` as captured at the most recent rising edge of `clk`.
- R5: The two groups are independent. Changing the mode or raw inputs of one group never changes the outputs of the other group.
- R6: After an edge with `rst` high, `pc_valid` and `oe_valid` are 0. After the first edge with `rst` low, both are 1.
- R7: While `oe_sync_mode` is 1 and `oe_valid` is 0, `oe_n` is all ones (all ports disabled).
- R8: The staging registers capture on every edge, whatever the mode. Raising a mode input after a pre-clock, with no further edge, makes the outputs show the pre-clocked values immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_sync_mode | input | 1 | Path-control group: 1 selects staged mode, 0 selects direct mode |
| oe_sync_mode | input | 1 | Output-enable group: 1 selects staged mode, 0 selects direct mode |
| a2x_sel_in | input | 2 | Raw A-side-to-X-side path control |
| x2a_sel_in | input | 2 | Raw X-side-to-A-side path control |
| xport_sel_in | input | 2 | Raw X-port source select |
| yport_sel_in | input | 1 | Raw Y-port source select |
| word_mode_in | input | 1 | Raw word-width select |
| in_load_in | input | 4 | Raw input-register load enables, active high |
| out_load_in | input | 4 | Raw output-register load enables, active high |
| oe_n_in | input | 6 | Raw port output enables, active low |
| a2x_sel | output | 2 | Effective A-to-X path control |
| x2a_sel | output | 2 | Effective X-to-A path control |
| xport_sel | output | 2 | Effective X-port select |
| yport_sel | output | 1 | Effective Y-port select |
| word_mode | output | 1 | Effective word-width select |
| in_load | output | 4 | Effective input-register load enables |
| out_load | output | 4 | Effective output-register load enables |
| oe_n | output | 6 | Effective port output enables, active low |
| pc_valid | output | 1 | Path-control staging holds data from an edge after reset |
| oe_valid | output | 1 | Output-enable staging holds data from an edge after reset |

## Verification
A staging register that misses a capture or captures the wrong field shows at the outputs in the first cycle its group is in staged mode. If it misses a capture made while the group was in direct mode, the fault appears the moment the mode input rises, before any further edge. A mode multiplexer wired to the wrong group shows as soon as one group's raw inputs change while the other group holds. A valid flag that sets too early or too late shows on `oe_n` in the one cycle between reset release and the first edge, when all enables must read as disabled.

// File: rtl/ctl_stager_pkg.sv
package ctl_stager_pkg;

    parameter int SEL_W  = 2;
    parameter int LOAD_N = 4;
    parameter int OE_N   = 6;

    typedef struct packed {
        logic [SEL_W-1:0]  a2x;
        logic [SEL_W-1:0]  x2a;
        logic [SEL_W-1:0]  xsel;
        logic              ysel;
        logic              word;
        logic [LOAD_N-1:0] ld_in;
        logic [LOAD_N-1:0] ld_out;
    } pc_ctl_t;

    localparam int PC_W = $bits(pc_ctl_t);

    typedef logic [OE_N-1:0] oe_vec_t;

    function automatic oe_vec_t oe_all_off();
        return '1;
    endfunction

endpackage

// File: rtl/ctl_stage_lane.sv
module ctl_stage_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] staged,
    output logic         valid
);

    // Data capture runs on every edge regardless of mode.
    always_ff @(posedge clk) begin
        staged <= raw;
    end

    always_ff @(posedge clk) begin
        if (rst) valid <= 1'b0;
        else     valid <= 1'b1;
    end

endmodule

// File: rtl/ctl_stage_pick.sv
module ctl_stage_pick #(
    parameter int           W         = 8,
    parameter bit           GATE_IDLE = 1'b0,
    parameter logic [W-1:0] IDLE_VAL  = '0
) (
    input  logic         sync_mode,
    input  logic         valid,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] staged,
    output logic [W-1:0] eff
);

    generate
        if (GATE_IDLE) begin : g_gated
            always_comb begin
                if (!sync_mode)  eff = raw;
                else if (!valid) eff = IDLE_VAL;
                else             eff = staged;
            end
        end else begin : g_plain
            assign eff = sync_mode ? staged : raw;
        end
    endgenerate

endmodule

// File: rtl/ctl_stager.sv
module ctl_stager
    import ctl_stager_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_sync_mode,
    input  logic              oe_sync_mode,
    input  logic [SEL_W-1:0]  a2x_sel_in,
    input  logic [SEL_W-1:0]  x2a_sel_in,
    input  logic [SEL_W-1:0]  xport_sel_in,
    input  logic              yport_sel_in,
    input  logic              word_mode_in,
    input  logic [LOAD_N-1:0] in_load_in,
    input  logic [LOAD_N-1:0] out_load_in,
    input  logic [OE_N-1:0]   oe_n_in,
    output logic [SEL_W-1:0]  a2x_sel,
    output logic [SEL_W-1:0]  x2a_sel,
    output logic [SEL_W-1:0]  xport_sel,
    output logic              yport_sel,
    output logic              word_mode,
    output logic [LOAD_N-1:0] in_load,
    output logic [LOAD_N-1:0] out_load,
    output logic [OE_N-1:0]   oe_n,
    output logic              pc_valid,
    output logic              oe_valid
);

    pc_ctl_t pc_raw, pc_stg, pc_eff;
    oe_vec_t oe_stg;

    always_comb begin
        pc_raw.a2x    = a2x_sel_in;
        pc_raw.x2a    = x2a_sel_in;
        pc_raw.xsel   = xport_sel_in;
        pc_raw.ysel   = yport_sel_in;
        pc_raw.word   = word_mode_in;
        pc_raw.ld_in  = in_load_in;
        pc_raw.ld_out = out_load_in;
    end

    ctl_stage_lane #(.W(PC_W)) i_pc_lane (
        .clk    (clk),
        .rst    (rst),
        .raw    (pc_raw),
        .staged (pc_stg),
        .valid  (pc_valid)
    );

    ctl_stage_pick #(.W(PC_W), .GATE_IDLE(1'b0), .IDLE_VAL('0)) i_pc_pick (
        .sync_mode (pc_sync_mode),
        .valid     (pc_valid),
        .raw       (pc_raw),
        .staged    (pc_stg),
        .eff       (pc_eff)
    );

    ctl_stage_lane #(.W(OE_N)) i_oe_lane (
        .clk    (clk),
        .rst    (rst),
        .raw    (oe_n_in),
        .staged (oe_stg),
        .valid  (oe_valid)
    );

    ctl_stage_pick #(.W(OE_N), .GATE_IDLE(1'b1), .IDLE_VAL(oe_all_off())) i_oe_pick (
        .sync_mode (oe_sync_mode),
        .valid     (oe_valid),
        .raw       (oe_n_in),
        .staged    (oe_stg),
        .eff       (oe_n)
    );

    assign a2x_sel   = pc_eff.a2x;
    assign x2a_sel   = pc_eff.x2a;
    assign xport_sel = pc_eff.xsel;
    assign yport_sel = pc_eff.ysel;
    assign word_mode = pc_eff.word;
    assign in_load   = pc_eff.ld_in;
    assign out_load  = pc_eff.ld_out;

endmodule

// File: rtl/ctl_stager_chk.sv
module ctl_stager_chk
    import ctl_stager_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pc_sync_mode,
    input logic              oe_sync_mode,
    input logic [SEL_W-1:0]  a2x_sel_in,
    input logic [SEL_W-1:0]  x2a_sel_in,
    input logic [SEL_W-1:0]  xport_sel_in,
    input logic              yport_sel_in,
    input logic              word_mode_in,
    input logic [LOAD_N-1:0] in_load_in,
    input logic [LOAD_N-1:0] out_load_in,
    input logic [OE_N-1:0]   oe_n_in,
    input logic [SEL_W-1:0]  a2x_sel,
    input logic [SEL_W-1:0]  x2a_sel,
    input logic [SEL_W-1:0]  xport_sel,
    input logic              yport_sel,
    input logic              word_mode,
    input logic [LOAD_N-1:0] in_load,
    input logic [LOAD_N-1:0] out_load,
    input logic [OE_N-1:0]   oe_n,
    input logic              pc_valid,
    input logic              oe_valid
);

    logic [PC_W-1:0] raw_v, eff_v;
    assign raw_v = {a2x_sel_in, x2a_sel_in, xport_sel_in, yport_sel_in,
                    word_mode_in, in_load_in, out_load_in};
    assign eff_v = {a2x_sel, x2a_sel, xport_sel, yport_sel,
                    word_mode, in_load, out_load};

    assert_pc_direct_R1: assert property (@(posedge clk) disable iff (rst)
        !pc_sync_mode |-> eff_v == raw_v);

    assert_pc_staged_R2: assert property (@(posedge clk) disable iff (rst)
        (pc_sync_mode && pc_valid) |-> eff_v == $past(raw_v));

    assert_oe_direct_R3: assert property (@(posedge clk) disable iff (rst)
        !oe_sync_mode |-> oe_n == oe_n_in);

    assert_oe_staged_R4: assert property (@(posedge clk) disable iff (rst)
        (oe_sync_mode && oe_valid) |-> oe_n == $past(oe_n_in));

    assert_valid_set_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (pc_valid && oe_valid));

    assert_oe_blank_R7: assert property (@(posedge clk) disable iff (rst)
        (oe_sync_mode && !oe_valid) |-> oe_n == '1);

endmodule

bind ctl_stager ctl_stager_chk i_ctl_stager_chk (.*);

// File: tb/test_ctl_stager.sv
module test_ctl_stager;
    import ctl_stager_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pc_sync_mode = 1'b0;
    logic oe_sync_mode = 1'b1;
    pc_ctl_t pc_drv = '0;
    logic [OE_N-1:0] oe_drv = '0;

    logic [SEL_W-1:0]  a2x_sel, x2a_sel, xport_sel;
    logic              yport_sel, word_mode, pc_valid, oe_valid;
    logic [LOAD_N-1:0] in_load, out_load;
    logic [OE_N-1:0]   oe_n;
    logic [PC_W-1:0]   pc_obs;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    ctl_stager i_ctl_stager (
        .clk(clk), .rst(rst),
        .pc_sync_mode(pc_sync_mode), .oe_sync_mode(oe_sync_mode),
        .a2x_sel_in(pc_drv.a2x), .x2a_sel_in(pc_drv.x2a),
        .xport_sel_in(pc_drv.xsel), .yport_sel_in(pc_drv.ysel),
        .word_mode_in(pc_drv.word), .in_load_in(pc_drv.ld_in),
        .out_load_in(pc_drv.ld_out), .oe_n_in(oe_drv),
        .a2x_sel(a2x_sel), .x2a_sel(x2a_sel), .xport_sel(xport_sel),
        .yport_sel(yport_sel), .word_mode(word_mode), .in_load(in_load),
        .out_load(out_load), .oe_n(oe_n),
        .pc_valid(pc_valid), .oe_valid(oe_valid)
    );

    assign pc_obs = {a2x_sel, x2a_sel, xport_sel, yport_sel, word_mode, in_load, out_load};

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Wait for a rising edge, then move to a quiet point between edges.
    task automatic edge_step();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst = 1'b1; oe_sync_mode = 1'b1; pc_sync_mode = 1'b0;
        oe_drv = 6'b010101; pc_drv = 16'h1234;
        edge_step();
        check("R6 pc_valid in reset", 32'(pc_valid), 0);
        check("R6 oe_valid in reset", 32'(oe_valid), 0);
        check("R7 oe blank in reset", 32'(oe_n), 32'h3f);
        check("R1 direct during reset", 32'(pc_obs), 32'h1234);
        rst = 1'b0; #1;
        check("R7 oe blank before first edge", 32'(oe_n), 32'h3f);
        edge_step();
        check("R6 pc_valid after edge", 32'(pc_valid), 1);
        check("R6 oe_valid after edge", 32'(oe_valid), 1);
        check("R4 oe staged after first edge", 32'(oe_n), 32'h15);
    endtask

    task automatic t_pc_direct();
        pc_sync_mode = 1'b0;
        pc_drv = 16'hA5C3; #1;
        check("R1 pc direct A", 32'(pc_obs), 32'hA5C3);
        pc_drv = 16'h0F0F; #1;
        check("R1 pc direct B", 32'(pc_obs), 32'h0F0F);
    endtask

    task automatic t_pc_staged();
        pc_sync_mode = 1'b1;
        pc_drv = 16'h5A5A;
        edge_step();
        check("R2 pc staged capture", 32'(pc_obs), 32'h5A5A);
        pc_drv = 16'hFFFF; #1;
        check("R2 pc staged hold", 32'(pc_obs), 32'h5A5A);
        edge_step();
        check("R2 pc staged next", 32'(pc_obs), 32'hFFFF);
    endtask

    task automatic t_oe_direct();
        oe_sync_mode = 1'b0;
        oe_drv = 6'b000001; #1;
        check("R3 oe direct A", 32'(oe_n), 32'h01);
        oe_drv = 6'b111110; #1;
        check("R3 oe direct B", 32'(oe_n), 32'h3e);
    endtask

    task automatic t_oe_staged();
        oe_sync_mode = 1'b1;
        oe_drv = 6'b101010;
        edge_step();
        check("R4 oe staged capture", 32'(oe_n), 32'h2a);
        oe_drv = 6'b000000; #1;
        check("R4 oe staged hold", 32'(oe_n), 32'h2a);
        edge_step();
        check("R4 oe staged next", 32'(oe_n), 32'h00);
    endtask

    task automatic t_independent();
        pc_sync_mode = 1'b1; oe_sync_mode = 1'b0;
        pc_drv = 16'h1111; oe_drv = 6'b110011;
        edge_step();
        pc_drv = 16'h2222; oe_drv = 6'b001100; #1;
        check("R5 oe follows while pc holds", 32'(oe_n), 32'h0c);
        check("R5 pc holds while oe follows", 32'(pc_obs), 32'h1111);
        oe_sync_mode = 1'b1; #1;
        check("R5 oe mode change leaves pc", 32'(pc_obs), 32'h1111);
        pc_sync_mode = 1'b0; #1;
        check("R5 pc mode change leaves oe", 32'(oe_n), 32'h33);
    endtask

    task automatic t_preclock();
        pc_sync_mode = 1'b0; oe_sync_mode = 1'b0;
        pc_drv = 16'hBEEF; oe_drv = 6'b011110;
        edge_step();
        pc_drv = 16'h0000; oe_drv = 6'b111111;
        pc_sync_mode = 1'b1; oe_sync_mode = 1'b1; #1;
        check("R8 pc pre-clocked value", 32'(pc_obs), 32'hBEEF);
        check("R8 oe pre-clocked value", 32'(oe_n), 32'h1e);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_pc_direct();
                t_pc_staged();
                t_oe_direct();
                t_oe_staged();
                t_independent();
                t_preclock();
            end
            begin
                repeat (2000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule